// File: doc/BRIEF.md
# Redirection Entry Message Delivery Engine

This block turns interrupt requests on a bank of input pins into message-signalled writes. Each pin has a 64-bit redirection entry, held in a register file outside the block. The engine reads a pin's entry, builds the message address and data from the entry's fields, and offers the result on a valid/ready output. A request pulse on a pin is latched as pending. The lowest-numbered pin that can be delivered is loaded into the single output slot. The slot holds its message until the consumer accepts it.

The block also tracks level-triggered pins that are in service. It does this through the remote IRR bit of each entry. It does not write the entries itself. It emits one-cycle set and clear strobes for the remote IRR bit and the delivery status bit of each pin, and the register file applies them. When an end-of-interrupt vector arrives, every level-triggered pin programmed with that vector gets a remote IRR clear strobe.

Top module: `msi_route_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, msi_valid is low and every status strobe (rirr_set, rirr_clr, dstat_set, dstat_clr) is zero.
- R2: The entry fields used are destination in bits 63:56 and destination mode in bit 11. msi_addr is built as base_addr OR (destination ID << 12) OR (1 << 3) OR (destination mode << 2). In physical mode (bit 11 = 0) the destination ID is only bits 59:56. In logical mode (bit 11 = 1) it is all of bits 63:56.
- R3: msi_data is built as (trigger mode, bit 15) << 15 OR (remote IRR, bit 14) << 14 OR (delivery mode, bits 10:8) << 8 OR (vector, bits 7:0). Bits 31:16 are zero. The fields are taken from the entry as it is in the cycle the slot is loaded.
- R4: A request pulse on a pin whose mask bit (bit 16) is 1 is dropped. It raises no dstat_set strobe and never produces a message, even after the pin is unmasked.
- R5: A request pulse in cycle t, with the slot empty, makes msi_valid high in cycle t+2. When several pins are pending, the lowest-numbered deliverable pin is loaded first, and the others stay pending.
- R6: While msi_valid is high and msi_ready is low, msi_valid stays high and msi_addr and msi_data stay unchanged.
- R7: In the cycle a level-triggered pin's message is accepted (msi_valid and msi_ready both high), rirr_set pulses for that pin. dstat_clr pulses for a pin in the cycle its request is loaded into the slot, unless a new request on that pin arrives in the same cycle.
- R8: A level-triggered pin whose remote IRR bit is 1 stays pending and is not delivered. It is delivered after the bit is cleared.
- R9: When eoi_valid is high with vector V, rirr_clr pulses in that same cycle for every pin with trigger mode 1 whose vector equals V. Edge-triggered pins and pins with other vectors get no strobe.
- R10: dstat_set pulses in the same cycle as an accepted (unmasked) request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pulse | input | NPINS | One-cycle request pulse per pin |
| redir_flat | input | NPINS*64 | Redirection entries, pin i in bits 64*i+63 : 64*i |
| base_addr | input | ADDR_W | Message base address, normally 0xFEE00000 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msi_ready | input | 1 | Consumer accepts the message |
| msi_valid | output | 1 | Message slot holds a message |
| msi_addr | output | ADDR_W | Message address (the upper address word is zero) |
| msi_data | output | DATA_W | Message data |
| rirr_set | output | NPINS | Set remote IRR strobe per pin |
| rirr_clr | output | NPINS | Clear remote IRR strobe per pin |
| dstat_set | output | NPINS | Set delivery status strobe per pin |
| dstat_clr | output | NPINS | Clear delivery status strobe per pin |

## Verification
Some properties are checked on every cycle. The message stays stable while the consumer stalls. A masked pin or a blocked level pin is never loaded into the slot. A remote IRR set happens only on an accepted handshake, and a clear happens only with an end-of-interrupt. The field packing of address and data, the lowest-first ordering, the dropping of masked requests, and redelivery after an end-of-interrupt need a reference model, so only the bench scenarios show them. The bench applies the status strobes to its own copy of the entries, so the remote IRR cycle closes through the ports.

// File: rtl/msi_route_pkg.sv
package msi_route_pkg;

  localparam int ENTRY_W   = 64;
  localparam int VEC_W     = 8;
  localparam int DEST_LSB  = 12;
  localparam int HINT_BIT  = 3;
  localparam int MODE_BIT  = 2;

  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        trig;
    logic        rirr;
    logic        pol;
    logic        dstat;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } redir_t;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_pulse,
  input  logic [NPINS-1:0] mask_v,
  input  logic [NPINS-1:0] take_v,
  output logic [NPINS-1:0] accept_v,
  output logic [NPINS-1:0] pend_q
);

  logic [NPINS-1:0] pend_d;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign accept_v[g] = irq_pulse[g] & ~mask_v[g];
    assign pend_d[g]   = (pend_q[g] & ~take_v[g]) | accept_v[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else begin
        pend_q[g] <= pend_d[g];
      end
    end
  end

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);

  always_comb begin
    any    = |req;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    if (any) onehot[idx] = 1'b1;
  end

endmodule

// File: rtl/msg_build.sv
module msg_build
  import msi_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  redir_t            ent,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  logic [7:0]        dest_id;
  logic [ADDR_W-1:0] dest_term;
  logic [ADDR_W-1:0] hint_term;
  logic [ADDR_W-1:0] mode_term;

  always_comb begin
    dest_id   = ent.dmode ? ent.dest : {4'b0000, ent.dest[3:0]};
    dest_term = ADDR_W'(dest_id) << DEST_LSB;
    hint_term = ADDR_W'(1) << HINT_BIT;
    mode_term = ADDR_W'(ent.dmode) << MODE_BIT;
    addr      = base_addr | dest_term | hint_term | mode_term;
    data      = DATA_W'({ent.trig, ent.rirr, 3'b000, ent.dlv, ent.vec});
  end

endmodule

// File: rtl/eoi_match.sv
module eoi_match #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8
) (
  input  logic                        eoi_valid,
  input  logic [VEC_W-1:0]            eoi_vector,
  input  logic [NPINS-1:0][VEC_W-1:0] vec_v,
  input  logic [NPINS-1:0]            lvl_v,
  output logic [NPINS-1:0]            hit_v
);

  for (genvar g = 0; g < NPINS; g++) begin : g_cmp
    assign hit_v[g] = eoi_valid & lvl_v[g] & (vec_v[g] == eoi_vector);
  end

endmodule

// File: rtl/msi_route_engine.sv
module msi_route_engine
  import msi_route_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         irq_pulse,
  input  logic [NPINS*ENTRY_W-1:0] redir_flat,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic                     eoi_valid,
  input  logic [VEC_W-1:0]         eoi_vector,
  input  logic                     msi_ready,
  output logic                     msi_valid,
  output logic [ADDR_W-1:0]        msi_addr,
  output logic [DATA_W-1:0]        msi_data,
  output logic [NPINS-1:0]         rirr_set,
  output logic [NPINS-1:0]         rirr_clr,
  output logic [NPINS-1:0]         dstat_set,
  output logic [NPINS-1:0]         dstat_clr
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  redir_t                     ent [NPINS];
  logic [NPINS-1:0]           mask_v, lvl_v, rirr_v;
  logic [NPINS-1:0][VEC_W-1:0] vec_v;

  for (genvar g = 0; g < NPINS; g++) begin : g_unpack
    assign ent[g]    = redir_t'(redir_flat[g*ENTRY_W +: ENTRY_W]);
    assign mask_v[g] = ent[g].mask;
    assign lvl_v[g]  = ent[g].trig;
    assign rirr_v[g] = ent[g].rirr;
    assign vec_v[g]  = ent[g].vec;
  end

  // output slot state
  logic              val_q, val_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              lvl_q, lvl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic             fire, slot_free, cap;
  logic [NPINS-1:0] inflight_v, elig_v, take_v, deliver_v;
  logic [NPINS-1:0] accept_v, pend_q, hit_v;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [NPINS-1:0] pick_oh;
  redir_t           pick_ent;
  logic [ADDR_W-1:0] bld_addr;
  logic [DATA_W-1:0] bld_data;

  always_comb begin
    fire      = val_q & msi_ready;
    slot_free = ~val_q | msi_ready;
    for (int i = 0; i < NPINS; i++) begin
      inflight_v[i] = val_q && (idx_q == IDX_W'(i));
      deliver_v[i]  = fire && (idx_q == IDX_W'(i));
    end
    elig_v = pend_q & ~mask_v & ~(lvl_v & rirr_v) & ~inflight_v;
  end

  irq_pending #(.NPINS(NPINS)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pulse(irq_pulse),
    .mask_v   (mask_v),
    .take_v   (take_v),
    .accept_v (accept_v),
    .pend_q   (pend_q)
  );

  prio_pick #(.N(NPINS), .IDX_W(IDX_W)) u_pick (
    .req   (elig_v),
    .any   (pick_any),
    .idx   (pick_idx),
    .onehot(pick_oh)
  );

  assign pick_ent = ent[pick_idx];
  assign cap      = slot_free & pick_any;
  assign take_v   = cap ? pick_oh : '0;

  msg_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_build (
    .ent      (pick_ent),
    .base_addr(base_addr),
    .addr     (bld_addr),
    .data     (bld_data)
  );

  eoi_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_eoi (
    .eoi_valid (eoi_valid),
    .eoi_vector(eoi_vector),
    .vec_v     (vec_v),
    .lvl_v     (lvl_v),
    .hit_v     (hit_v)
  );

  // next state of the slot
  always_comb begin
    val_d  = val_q;
    idx_d  = idx_q;
    lvl_d  = lvl_q;
    addr_d = addr_q;
    data_d = data_q;
    if (cap) begin
      val_d  = 1'b1;
      idx_d  = pick_idx;
      lvl_d  = pick_ent.trig;
      addr_d = bld_addr;
      data_d = bld_data;
    end else if (fire) begin
      val_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      val_q <= val_d;
      idx_q <= idx_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign msi_valid = val_q;
  assign msi_addr  = addr_q;
  assign msi_data  = data_q;
  assign rirr_set  = lvl_q ? deliver_v : '0;
  assign rirr_clr  = hit_v & ~rirr_set;
  assign dstat_set = accept_v;
  assign dstat_clr = take_v & ~accept_v;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));

  // R4
  no_masked_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !pick_ent.mask);

  // R8
  no_blocked_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !(pick_ent.trig && pick_ent.rirr));

  // R7
  rirr_set_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_set) |-> (msi_valid && msi_ready));

  // R9
  rirr_clr_on_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_clr) |-> eoi_valid);

endmodule

// File: tb/sim_msi_route_engine.sv
module sim_msi_route_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     irq;
  logic [NP*64-1:0]  flat;
  logic [31:0]       base;
  logic              eoi;
  logic [7:0]        eoi_vec;
  logic              rdy;
  logic              msi_valid;
  logic [31:0]       msi_addr, msi_data;
  logic [NP-1:0]     rirr_set, rirr_clr, dstat_set, dstat_clr;

  logic [63:0] ent [NP];
  always_comb for (int i = 0; i < NP; i++) flat[i*64 +: 64] = ent[i];

  msi_route_engine u0 (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq), .redir_flat(flat),
    .base_addr(base), .eoi_valid(eoi), .eoi_vector(eoi_vec),
    .msi_ready(rdy), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
    .dstat_set(dstat_set), .dstat_clr(dstat_clr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] dest, input bit msk, input bit trig,
                                     input bit dm, input logic [2:0] dlv, input logic [7:0] vec);
    return {dest, 39'b0, msk, trig, 1'b0, 1'b0, 1'b0, dm, dlv, vec};
  endfunction

  function automatic logic [31:0] ref_addr(input logic [63:0] e);
    logic [31:0] id;
    id = e[11] ? {24'b0, e[63:56]} : {28'b0, e[59:56]};
    return base | (id << 12) | 32'h8 | (e[11] ? 32'h4 : 32'h0);
  endfunction

  function automatic logic [31:0] ref_data(input logic [63:0] e);
    return {16'b0, e[15], e[14], 3'b000, e[10:8], e[7:0]};
  endfunction

  // reference model state
  bit          m_pend [NP];
  bit          m_val;
  int          m_idx;
  logic [31:0] m_addr, m_data;
  bit          m_lvl;

  bit            s_have, s_cap, s_fire;
  int            s_pick;
  logic [NP-1:0] s_acc, s_take, s_rset, s_rclr;
  logic [31:0]   s_naddr, s_ndata;
  bit            s_nlvl;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      s_acc = '0; s_take = '0; s_rset = '0; s_rclr = '0;
      for (int i = 0; i < NP; i++) if (irq[i] && !ent[i][16]) s_acc[i] = 1'b1;
      s_fire = m_val && rdy;
      s_pick = -1;
      for (int i = 0; i < NP; i++)
        if (s_pick < 0 && m_pend[i] && !ent[i][16] && !(ent[i][15] && ent[i][14])
            && !(m_val && m_idx == i)) s_pick = i;
      s_cap = (!m_val || rdy) && s_pick >= 0;
      if (s_cap) begin
        s_take[s_pick] = 1'b1;
        s_naddr = ref_addr(ent[s_pick]);
        s_ndata = ref_data(ent[s_pick]);
        s_nlvl  = ent[s_pick][15];
      end
      if (s_fire && m_lvl) s_rset[m_idx] = 1'b1;
      for (int i = 0; i < NP; i++)
        if (eoi && ent[i][7:0] == eoi_vec && ent[i][15] && !s_rset[i]) s_rclr[i] = 1'b1;
      chk("R5 R6 msi_valid", 64'(msi_valid), 64'(m_val));
      if (m_val) begin
        chk("R2 msi_addr", 64'(msi_addr), 64'(m_addr));
        chk("R3 msi_data", 64'(msi_data), 64'(m_data));
      end
      chk("R7 rirr_set", 64'(rirr_set), 64'(s_rset));
      chk("R9 rirr_clr", 64'(rirr_clr), 64'(s_rclr));
      chk("R4 R10 dstat_set", 64'(dstat_set), 64'(s_acc));
      chk("R7 dstat_clr", 64'(dstat_clr), 64'(s_take & ~s_acc));
      s_have = 1;
    end else begin
      s_have = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_pend[i] <= 1'b0;
      m_val <= 1'b0;
      m_idx <= 0;
      m_lvl <= 1'b0;
    end else if (s_have) begin
      for (int i = 0; i < NP; i++) begin
        m_pend[i] <= (m_pend[i] && !s_take[i]) || s_acc[i];
        if (s_rset[i]) ent[i][14] <= 1'b1;
        else if (s_rclr[i]) ent[i][14] <= 1'b0;
        if (s_acc[i]) ent[i][12] <= 1'b1;
        else if (s_take[i]) ent[i][12] <= 1'b0;
      end
      if (s_cap) begin
        m_val <= 1'b1; m_idx <= s_pick; m_addr <= s_naddr;
        m_data <= s_ndata; m_lvl <= s_nlvl;
      end else if (s_fire) begin
        m_val <= 1'b0;
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired, run hung (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input logic [NP-1:0] p, input bit e, input logic [7:0] v);
    @(negedge clk);
    irq = p; eoi = e; eoi_vec = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, 1'b0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; irq = '0; eoi = 1'b0; eoi_vec = '0; rdy = 1'b1; base = 32'hFEE0_0000;
    for (int i = 0; i < NP; i++) ent[i] = mk(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    repeat (3) @(negedge clk);
    #3 chk("R1 valid in reset", 64'(msi_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk("R1 valid after reset", 64'(msi_valid), 64'd0);
    chk("R1 strobes after reset", 64'(rirr_set | rirr_clr | dstat_set | dstat_clr), 64'd0);

    // physical, edge
    ent[3] = mk(8'hA5, 1'b0, 1'b0, 1'b0, 3'd0, 8'h31);
    step(NP'(1) << 3, 1'b0, 8'h00);
    #3 chk("R10 dstat_set on request", 64'(dstat_set), 64'(NP'(1) << 3));
    idle(1);
    #3 chk("R7 dstat_clr on load", 64'(dstat_clr), 64'(NP'(1) << 3));
    idle(1);
    #3;
    chk("R5 valid at t+2", 64'(msi_valid), 64'd1);
    chk("R2 physical addr", 64'(msi_addr), 64'h0000_0000_FEE0_5008);
    chk("R3 edge data", 64'(msi_data), 64'h31);
    idle(2);

    // logical, level
    ent[5] = mk(8'hA5, 1'b0, 1'b1, 1'b1, 3'd1, 8'h42);
    step(NP'(1) << 5, 1'b0, 8'h00);
    idle(2);
    #3;
    chk("R2 logical addr", 64'(msi_addr), 64'h0000_0000_FEEA_500C);
    chk("R3 level data", 64'(msi_data), 64'h8142);
    chk("R7 rirr_set on accept", 64'(rirr_set), 64'(NP'(1) << 5));
    idle(1);
    step(NP'(1) << 5, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      idle(1);
      #3 chk("R8 blocked level pin", 64'(msi_valid), 64'd0);
    end
    step('0, 1'b1, 8'h42);
    #3 chk("R9 eoi clears level pin", 64'(rirr_clr), 64'(NP'(1) << 5));
    idle(2);
    #3;
    chk("R8 redelivered after eoi", 64'(msi_valid), 64'd1);
    chk("R8 redelivered data", 64'(msi_data), 64'h8142);
    idle(2);

    // masked pin
    ent[7] = mk(8'h01, 1'b1, 1'b0, 1'b0, 3'd0, 8'h77);
    step(NP'(1) << 7, 1'b0, 8'h00);
    #3 chk("R4 masked no dstat_set", 64'(dstat_set), 64'd0);
    for (int k = 0; k < 3; k++) begin
      idle(1);
      #3 chk("R4 masked no message", 64'(msi_valid), 64'd0);
    end
    ent[7][16] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      idle(1);
      #3 chk("R4 dropped after unmask", 64'(msi_valid), 64'd0);
    end

    // priority with stalled consumer
    ent[2]  = mk(8'h01, 1'b0, 1'b0, 1'b0, 3'd0, 8'h22);
    ent[10] = mk(8'h01, 1'b0, 1'b0, 1'b0, 3'd0, 8'h2A);
    ent[20] = mk(8'h01, 1'b0, 1'b0, 1'b0, 3'd0, 8'h34);
    step((NP'(1) << 2) | (NP'(1) << 10) | (NP'(1) << 20), 1'b0, 8'h00);
    rdy = 1'b0;
    idle(2);
    #3 chk("R5 lowest pin first", 64'(msi_data), 64'h22);
    for (int k = 0; k < 2; k++) begin
      idle(1);
      #3;
      chk("R6 hold data", 64'(msi_data), 64'h22);
      chk("R6 hold valid", 64'(msi_valid), 64'd1);
    end
    idle(1);
    rdy = 1'b1;
    #3 chk("R6 accepted cycle", 64'(msi_data), 64'h22);
    idle(1);
    #3 chk("R5 second pin", 64'(msi_data), 64'h2A);
    idle(1);
    #3 chk("R5 third pin", 64'(msi_data), 64'h34);
    idle(2);

    // shared vector end-of-interrupt
    ent[12] = mk(8'h01, 1'b0, 1'b1, 1'b0, 3'd0, 8'h60);
    ent[13] = mk(8'h02, 1'b0, 1'b1, 1'b1, 3'd0, 8'h60);
    ent[14] = mk(8'h03, 1'b0, 1'b0, 1'b0, 3'd0, 8'h60);
    ent[14][14] = 1'b1;
    step((NP'(1) << 12) | (NP'(1) << 13) | (NP'(1) << 14), 1'b0, 8'h00);
    idle(6);
    step('0, 1'b1, 8'h61);
    #3 chk("R9 other vector no clear", 64'(rirr_clr), 64'd0);
    step('0, 1'b1, 8'h60);
    #3 chk("R9 level pins only", 64'(rirr_clr), 64'((NP'(1) << 12) | (NP'(1) << 13)));
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule